// File: doc/BRIEF.md
# Phase-2 Register-Select Bus Front End

This block is the host-side front end of a 65xx-style peripheral that exposes sixteen byte-wide registers. It watches a phase-2 clock input, a pair of chip selects (one active high, one active low), four register-select lines, a read/write line and a byte of write data. From these it works out which register a bus cycle targets, and whether the cycle is selected at all. For each selected cycle it issues a one-hot read or write strobe. It also holds a small register bank so that every access can be seen at the ports.

One register carries a read side effect. Any selected access to the shift-data register clears an interrupt flag, which an external event input sets. The flag can be read back through a read-only flag register.

A mode parameter chooses how the register-select lines are captured:
- **Edge mode** samples them on every phase-2 rise.
- **Qualified mode** samples them only while the chip is selected during the phase-2-low interval. In this mode a cycle whose select drops early still reaches the register it was aimed at, even if the address lines wander before the rise.

Everything runs on one fast system clock. Phase 2 is a sampled input.

Top module: `phi_bus_front`

## Requirements
- R1: After reset every bank register reads 0x00, the interrupt flag is clear, and no strobe or data enable is active.
- R2: In a selected cycle whose read/write line is low at the phase-2 rise, exactly one write strobe is high, for exactly one clock. Its bit matches the captured register number, and that register then holds the write data. Register 13 is read-only and ignores writes.
- R3: The data enable is high only during phase-2 high of a selected read cycle. While it is high, the data output carries the captured register's content. Register 13 reads as the interrupt flag in bit 2, with all other bits zero.
- R4: A cycle in which the chip is never selected, neither during phase-2 low nor at the rise, produces no strobe. It leaves every register and the interrupt flag unchanged.
- R5: The event input sets the interrupt flag. A selected read or write of register 10 clears it, and a set in the same clock wins over the clear.
- R6: In edge mode, the register number is the value on the select lines at the phase-2 rise. If the select drops and the address changes before the rise, the write goes to the new address.
- R7: In qualified mode, the register number is the last value seen while selected during phase-2 low. The same late address change leaves the intended register written and the other untouched.
- R8: If the read/write line returns high before the phase-2 rise, no write is performed in either mode.
- R9: The chip counts as selected only when the high-active select is 1 and the low-active select is 0. Any other combination is unselected.
- R10: In a selected cycle whose read/write line is high at the rise, exactly one read strobe is high, for one clock, at the captured register number. No write strobe is high in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | Sampled phase-2 bus clock |
| cs_hi | input | 1 | High-active chip select |
| cs_lo_n | input | 1 | Low-active chip select |
| rsel | input | 4 | Register-select lines |
| rd_nwr | input | 1 | High for read, low for write |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host (zero when not enabled) |
| doe | output | 1 | Read data drive enable; the bus is high-impedance when low |
| wr_stb | output | 16 | One-hot write strobes |
| rd_stb | output | 16 | One-hot read strobes |
| sr_event | input | 1 | Sets the shift interrupt flag |
| irq_sr | output | 1 | Shift interrupt flag |

## Verification
The bench builds two copies side by side on shared stimulus: one with the default edge-latching mode and one in qualified mode, both at sixteen registers and byte width. Running them together lets a single early-deselect, late-address write show the misdirected write in one copy and the correctly targeted write in the other. The same setup shows that an early end of the write cycle is lost in both. Random cycles with mixed select patterns, late address moves and flag events keep separate bank and flag models for each copy.

// File: rtl/phi_bus_pkg.sv
`timescale 1ns/1ps
package phi_bus_pkg;
   typedef enum logic {
      LATCH_EDGE = 1'b0,
      LATCH_QUAL = 1'b1
   } latch_mode_e;

   localparam int DEF_NUM_REGS = 16;
   localparam int DEF_DATA_W   = 8;
   localparam int DEF_SR_REG   = 10;
   localparam int DEF_IFR_REG  = 13;
   localparam int DEF_SR_BIT   = 2;
endpackage

// File: rtl/phi_addr_capture.sv
`timescale 1ns/1ps
module phi_addr_capture #(
   parameter int RS_W = 4,
   parameter phi_bus_pkg::latch_mode_e MODE = phi_bus_pkg::LATCH_EDGE
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            phi2,
   input  logic            sel_now,
   input  logic [RS_W-1:0] rsel,
   input  logic            rd_nwr,
   output logic            start,
   output logic            phase_hi,
   output logic            cyc_sel,
   output logic            cyc_rnw,
   output logic [RS_W-1:0] cyc_addr
);
   logic            sel_low;
   logic [RS_W-1:0] addr_at_rise;
   logic            rise;

   assign rise = phi2 & ~phase_hi;

   generate
      if (MODE == phi_bus_pkg::LATCH_QUAL) begin : g_qual
         logic [RS_W-1:0] addr_hold;
         always_ff @(posedge clk) begin
            if (!rst_n)
               addr_hold <= '0;
            else if (!phi2 && sel_now)
               addr_hold <= rsel;
         end
         assign addr_at_rise = sel_now ? rsel : addr_hold;
      end else begin : g_edge
         assign addr_at_rise = rsel;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_hi <= 1'b0;
         start    <= 1'b0;
         sel_low  <= 1'b0;
         cyc_sel  <= 1'b0;
         cyc_rnw  <= 1'b1;
         cyc_addr <= '0;
      end else begin
         phase_hi <= phi2;
         start    <= rise;
         if (rise)
            sel_low <= 1'b0;
         else if (!phi2 && sel_now)
            sel_low <= 1'b1;
         if (rise) begin
            cyc_sel  <= sel_low | sel_now;
            cyc_rnw  <= rd_nwr;
            cyc_addr <= addr_at_rise;
         end
      end
   end
endmodule

// File: rtl/phi_strobe_decode.sv
`timescale 1ns/1ps
module phi_strobe_decode #(
   parameter int NUM_REGS = 16,
   localparam int RS_W = $clog2(NUM_REGS)
) (
   input  logic                start,
   input  logic                cyc_sel,
   input  logic                cyc_rnw,
   input  logic [RS_W-1:0]     cyc_addr,
   output logic [NUM_REGS-1:0] wr_stb,
   output logic [NUM_REGS-1:0] rd_stb
);
   logic wr_en, rd_en;
   assign wr_en = start & cyc_sel & ~cyc_rnw;
   assign rd_en = start & cyc_sel &  cyc_rnw;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
      logic hit;
      assign hit       = (cyc_addr == RS_W'(i));
      assign wr_stb[i] = wr_en & hit;
      assign rd_stb[i] = rd_en & hit;
   end
endmodule

// File: rtl/phi_reg_bank.sv
`timescale 1ns/1ps
module phi_reg_bank #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 8,
   parameter int SR_REG   = 10,
   parameter int IFR_REG  = 13,
   parameter int SR_BIT   = 2,
   localparam int RS_W = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_REGS-1:0] wr_stb,
   input  logic [NUM_REGS-1:0] rd_stb,
   input  logic [DATA_W-1:0]   din,
   input  logic [RS_W-1:0]     rd_addr,
   input  logic                rd_oe,
   input  logic                sr_event,
   output logic [DATA_W-1:0]   dout,
   output logic                irq_sr
);
   logic [DATA_W-1:0] bank [NUM_REGS];
   logic              sr_clr;

   assign sr_clr = wr_stb[SR_REG] | rd_stb[SR_REG];

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_sr <= 1'b0;
      else if (sr_event)
         irq_sr <= 1'b1;
      else if (sr_clr)
         irq_sr <= 1'b0;
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (i == IFR_REG) begin : g_flag
         logic [DATA_W-1:0] flag_view;
         always_comb begin
            flag_view         = '0;
            flag_view[SR_BIT] = irq_sr;
         end
         assign bank[i] = flag_view;
      end else begin : g_store
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (wr_stb[i])
               q <= din;
         end
         assign bank[i] = q;
      end
   end

   assign dout = rd_oe ? bank[rd_addr] : '0;
endmodule

// File: rtl/phi_bus_front.sv
`timescale 1ns/1ps
module phi_bus_front #(
   parameter int NUM_REGS = phi_bus_pkg::DEF_NUM_REGS,
   parameter int DATA_W   = phi_bus_pkg::DEF_DATA_W,
   parameter int SR_REG   = phi_bus_pkg::DEF_SR_REG,
   parameter int IFR_REG  = phi_bus_pkg::DEF_IFR_REG,
   parameter int SR_BIT   = phi_bus_pkg::DEF_SR_BIT,
   parameter phi_bus_pkg::latch_mode_e LATCH_MODE = phi_bus_pkg::LATCH_EDGE,
   localparam int RS_W = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                phi2,
   input  logic                cs_hi,
   input  logic                cs_lo_n,
   input  logic [RS_W-1:0]     rsel,
   input  logic                rd_nwr,
   input  logic [DATA_W-1:0]   din,
   output logic [DATA_W-1:0]   dout,
   output logic                doe,
   output logic [NUM_REGS-1:0] wr_stb,
   output logic [NUM_REGS-1:0] rd_stb,
   input  logic                sr_event,
   output logic                irq_sr
);
   initial begin
      assert ((1 << RS_W) == NUM_REGS && NUM_REGS >= 2)
         else $fatal(1, "register count must be a power of two");
      assert (SR_REG < NUM_REGS && IFR_REG < NUM_REGS && SR_REG != IFR_REG)
         else $fatal(1, "special register index out of range");
      assert (SR_BIT < DATA_W)
         else $fatal(1, "flag bit outside data width");
   end

   logic            sel_now;
   logic            start, phase_hi, cyc_sel, cyc_rnw;
   logic [RS_W-1:0] cyc_addr;

   assign sel_now = cs_hi & ~cs_lo_n;

   phi_addr_capture #(.RS_W(RS_W), .MODE(LATCH_MODE)) cap_i (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .sel_now(sel_now),
      .rsel(rsel), .rd_nwr(rd_nwr), .start(start), .phase_hi(phase_hi),
      .cyc_sel(cyc_sel), .cyc_rnw(cyc_rnw), .cyc_addr(cyc_addr)
   );

   phi_strobe_decode #(.NUM_REGS(NUM_REGS)) dec_i (
      .start(start), .cyc_sel(cyc_sel), .cyc_rnw(cyc_rnw),
      .cyc_addr(cyc_addr), .wr_stb(wr_stb), .rd_stb(rd_stb)
   );

   assign doe = phase_hi & cyc_sel & cyc_rnw;

   phi_reg_bank #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SR_REG(SR_REG),
      .IFR_REG(IFR_REG), .SR_BIT(SR_BIT)
   ) bank_i (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .din(din), .rd_addr(cyc_addr), .rd_oe(doe), .sr_event(sr_event),
      .dout(dout), .irq_sr(irq_sr)
   );
endmodule

// File: rtl/phi_bus_front_chk.sv
`timescale 1ns/1ps
module phi_bus_front_chk #(
   parameter int NUM_REGS = 16,
   parameter int SR_REG   = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                phi2,
   input logic                doe,
   input logic [NUM_REGS-1:0] wr_stb,
   input logic [NUM_REGS-1:0] rd_stb,
   input logic                sr_event,
   input logic                irq_sr
);
   assert_wr_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_stb));

   assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_stb) |=> !(|wr_stb));

   assert_rd_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_stb));

   assert_no_mix_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !((|wr_stb) && (|rd_stb)));

   assert_strobe_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((|wr_stb) || (|rd_stb)) |-> ($past(phi2) && !$past(phi2, 2)));

   assert_doe_high_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      doe |-> $past(phi2));

   assert_sr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_stb[SR_REG] || rd_stb[SR_REG]) && !sr_event) |=> !irq_sr);

   assert_sr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sr_event |=> irq_sr);
endmodule

bind phi_bus_front phi_bus_front_chk #(.NUM_REGS(NUM_REGS), .SR_REG(SR_REG)) chk_i (
   .clk(clk), .rst_n(rst_n), .phi2(phi2), .doe(doe), .wr_stb(wr_stb),
   .rd_stb(rd_stb), .sr_event(sr_event), .irq_sr(irq_sr)
);

// File: tb/phi_bus_front_tb_top.sv
`timescale 1ns/1ps
module phi_bus_front_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic phi2 = 1'b0, cs_hi = 1'b0, cs_lo_n = 1'b1, rd_nwr = 1'b1, sr_event = 1'b0;
   logic [3:0] rsel = '0;
   logic [7:0] din = '0;
   logic [7:0]  dout_e, dout_q;
   logic        doe_e, doe_q, irq_e, irq_q;
   logic [15:0] wr_e, wr_q, rd_e, rd_q;

   int errors = 0, checks = 0;
   bit finished = 0;
   logic [7:0] mem [2][16];
   bit         flag [2];

   always #2 clk = ~clk;

   phi_bus_front dut_i (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
      .rsel(rsel), .rd_nwr(rd_nwr), .din(din), .dout(dout_e), .doe(doe_e),
      .wr_stb(wr_e), .rd_stb(rd_e), .sr_event(sr_event), .irq_sr(irq_e)
   );

   phi_bus_front #(.LATCH_MODE(phi_bus_pkg::LATCH_QUAL)) dut_q (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
      .rsel(rsel), .rd_nwr(rd_nwr), .din(din), .dout(dout_q), .doe(doe_q),
      .wr_stb(wr_q), .rd_stb(rd_q), .sr_event(sr_event), .irq_sr(irq_q)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] onehot(input logic [3:0] a);
      return 16'h1 << a;
   endfunction

   function automatic logic [7:0] read_val(input int k, input logic [3:0] a);
      if (a == 4'd13) return {5'b0, flag[k], 2'b0};
      return mem[k][a];
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   // cs_pat: bit1 drives cs_hi, bit0 drives cs_lo_n
   task automatic bus_cycle(input logic [3:0] a, input bit rnw, input logic [7:0] d,
                            input logic [1:0] cs_pat, input bit early,
                            input logic [3:0] late, input bit abort, input bit ev,
                            input string tag);
      bit sel_low, sel_rise, csel, rnw_r;
      logic [3:0] addr [2];
      logic [15:0] wr_act [2], rd_act [2];
      logic [7:0]  d_act [2];
      logic        oe_act [2], irq_act [2];
      phi2 = 1'b0; cs_hi = cs_pat[1]; cs_lo_n = cs_pat[0];
      rsel = a; rd_nwr = rnw; din = d;
      tick();
      if (ev) sr_event = 1'b1;
      tick();
      sr_event = 1'b0;
      if (ev) begin flag[0] = 1; flag[1] = 1; end
      chk({tag, " R3 doe low in phase low"}, {31'b0, doe_e | doe_q}, 0);
      sel_low = (cs_pat == 2'b10);
      sel_rise = sel_low;
      rnw_r = rnw;
      addr[0] = a; addr[1] = a;
      if (early && sel_low) begin
         cs_hi = 1'b0; cs_lo_n = 1'b1; rsel = late;
         sel_rise = 0; addr[0] = late;
      end
      if (abort) begin rd_nwr = 1'b1; rnw_r = 1; end
      tick(); tick();
      phi2 = 1'b1;
      tick();
      csel = sel_low | sel_rise;
      wr_act[0] = wr_e; wr_act[1] = wr_q; rd_act[0] = rd_e; rd_act[1] = rd_q;
      oe_act[0] = doe_e; oe_act[1] = doe_q; d_act[0] = dout_e; d_act[1] = dout_q;
      for (int k = 0; k < 2; k++) begin
         chk({tag, " R2 wr strobe"}, {16'b0, wr_act[k]}, (csel && !rnw_r) ? onehot(addr[k]) : 0);
         chk({tag, " R10 rd strobe"}, {16'b0, rd_act[k]}, (csel && rnw_r) ? onehot(addr[k]) : 0);
         chk({tag, " R3 doe"}, {31'b0, oe_act[k]}, {31'b0, csel && rnw_r});
         if (csel && rnw_r)
            chk({tag, " R3 read data"}, {24'b0, d_act[k]}, {24'b0, read_val(k, addr[k])});
         if (csel && !rnw_r && addr[k] != 4'd13) mem[k][addr[k]] = d;
         if (csel && addr[k] == 4'd10) flag[k] = 0;
      end
      tick();
      chk({tag, " R2 strobe one clock"}, {16'b0, wr_e | wr_q | rd_e | rd_q}, 0);
      irq_act[0] = irq_e; irq_act[1] = irq_q;
      for (int k = 0; k < 2; k++)
         chk({tag, " R5 flag"}, {31'b0, irq_act[k]}, {31'b0, flag[k]});
      tick(); tick();
      phi2 = 1'b0; cs_hi = 1'b0; cs_lo_n = 1'b1; rd_nwr = 1'b1;
   endtask

   task automatic rd(input logic [3:0] a, input string tag);
      bus_cycle(a, 1, 8'h00, 2'b10, 0, 0, 0, 0, tag);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
      bus_cycle(a, 0, d, 2'b10, 0, 0, 0, 0, tag);
   endtask

   initial begin
      #800000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int k = 0; k < 2; k++) begin
         flag[k] = 0;
         for (int r = 0; r < 16; r++) mem[k][r] = 8'h00;
      end
      repeat (4) tick();
      chk("R1 strobes at reset", {wr_e | wr_q | rd_e | rd_q}, 0);
      chk("R1 doe and flag at reset", {29'b0, doe_e, doe_q, irq_e | irq_q}, 0);
      rst_n = 1'b1;
      tick();
      for (int r = 0; r < 16; r++) rd(r[3:0], "R1 reset contents");
      wr(4'd5, 8'hA5, "R2 write"); rd(4'd5, "R3 readback");
      wr(4'd13, 8'hFF, "R2 ifr read-only"); rd(4'd13, "R2 ifr read-only");
      // R6/R7: early deselect then late address move
      bus_cycle(4'd3, 0, 8'h11, 2'b10, 1, 4'd7, 0, 0, "R6 R7 late addr");
      rd(4'd3, "R7 intended target"); rd(4'd7, "R6 misdirected target");
      // R8: write cycle ended before rise
      bus_cycle(4'd4, 0, 8'h5A, 2'b10, 0, 0, 1, 0, "R8 abort");
      rd(4'd4, "R8 no write");
      // R9: all non-selecting patterns
      bus_cycle(4'd6, 0, 8'h77, 2'b00, 0, 0, 0, 0, "R9 pat00");
      bus_cycle(4'd6, 0, 8'h77, 2'b01, 0, 0, 0, 0, "R9 pat01");
      bus_cycle(4'd6, 0, 8'h77, 2'b11, 0, 0, 0, 0, "R9 pat11");
      rd(4'd6, "R4 R9 untouched");
      // R5 / R4 flag behaviour
      bus_cycle(4'd13, 1, 0, 2'b10, 0, 0, 0, 1, "R5 set and read");
      bus_cycle(4'd10, 1, 0, 2'b00, 0, 0, 0, 0, "R4 unselected sr read");
      rd(4'd13, "R4 flag kept");
      rd(4'd10, "R5 sr read clears");
      rd(4'd13, "R5 flag cleared");
      bus_cycle(4'd10, 0, 8'h3C, 2'b10, 0, 0, 0, 1, "R5 set then sr write");
      rd(4'd13, "R5 flag after write");
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [3:0] a, late;
         logic [1:0] pat;
         bit rnw, early, abort, ev;
         a = 4'($urandom_range(0, 15));
         late = 4'($urandom_range(0, 15));
         pat = ($urandom_range(0, 3) != 0) ? 2'b10 : 2'($urandom_range(0, 3));
         rnw = $urandom_range(0, 1) != 0;
         early = $urandom_range(0, 5) == 0;
         abort = !rnw && ($urandom_range(0, 7) == 0);
         ev = $urandom_range(0, 4) == 0;
         bus_cycle(a, rnw, 8'($urandom), pat, early, late, abort, ev, "R2 R10 random");
      end
      for (int r = 0; r < 16; r++) rd(r[3:0], "R6 R7 final bank");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule